// File: doc/BRIEF.md
# SDRAM power-up initialization sequencer

This block takes a single-rank 16-bit SDRAM from reset to a usable state. After reset is released it drives clock enable high. It then holds the command bus idle for a long, parameterised stabilisation period and issues a precharge of all banks. Next come a programmable number of auto-refresh commands, and finally a load of the device mode register. Each gap between two commands is counted in clocks from its own parameter, so the row-precharge, row-cycle and mode-register-set times can be matched to the device at hand.

When the last gap has elapsed, a done flag rises and stays high until the next reset. An access engine alongside then takes over the command bus. From that point the sequencer drives only idle commands. The mode word is put together at elaboration from four fields: burst length code, burst type, CAS latency and write-burst mode. The defaults give a burst of two, sequential order, CAS latency 3, standard operating mode and single-location writes.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, the outputs are: sd_cke = 0, a NOP command ({cs_n,ras_n,cas_n,we_n} = 0111), sd_addr = 0, sd_ba = 0 and init_done = 0. Reset wins over a command that would otherwise be issued in the same cycle.
- R2: sd_cke rises on the second rising clock edge after reset is released and stays high until reset. No command other than NOP is driven while sd_cke is low.
- R3: A precharge-all command (0010) appears exactly STABLE_CYCLES clocks after sd_cke rises. During it sd_addr bit 10 is 1, all other sd_addr bits are 0 and sd_ba is 0.
- R4: Exactly REFRESH_COUNT auto-refresh commands (0001) follow the precharge-all. The first comes exactly T_RP clocks after it, and each has sd_addr = 0 and sd_ba = 0.
- R5: Consecutive auto-refresh commands are exactly T_RC clocks apart. The load-mode command comes exactly T_RC clocks after the last auto-refresh.
- R6: The load-mode command (0000) drives sd_ba = 0 and a mode word on sd_addr. The word has burst length code in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, operating mode 00 in bits 8:7 and write-burst mode in bit 9; the defaults give 0x231.
- R7: init_done rises exactly T_MRD clocks after the load-mode command and stays high until reset. While it is high only NOP is driven.
- R8: Every cycle that carries no command drives NOP. Chip select is low throughout, and only the four codes NOP, precharge, refresh and load-mode ever appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (A10 flag, mode word) |
| sd_ba | output | BANK_W | Bank address |
| init_done | output | 1 | Sequence complete; bus free for the access engine |

## Verification
The case that matters most is reset landing in the very cycle in which the controller has decided to issue an auto-refresh. The command register and the reset then compete at one edge. The bench provokes this by raising reset on the clock cycle just before the second refresh of a run would appear on the pins. It then requires NOP with clock enable low at the next sample, and no trace of that refresh. It also requires a complete, correctly timed sequence after the release that follows. Every command, the clock-enable rise and the done rise are compared to their expected cycle and address through a queue of predicted events.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    // Abstract command requested by the controller
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_LMR = 2'd3
    } sd_cmd_e;

    // Physical command pins, all active low
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_pins_t;

    localparam sd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic sd_pins_t encode_cmd(sd_cmd_e c);
        sd_pins_t p;
        case (c)
            CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            CMD_LMR: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default: p = PINS_NOP;
        endcase
        return p;
    endfunction

    // Mode register field positions (decoded by the SDRAM device)
    localparam int MR_BL_LSB = 0;
    localparam int MR_BT_BIT = 3;
    localparam int MR_CL_LSB = 4;
    localparam int MR_OP_LSB = 7;
    localparam int MR_WB_BIT = 9;

    function automatic logic [15:0] mode_word(int bl_code, int burst_type, int cas_lat, int wb_single);
        logic [15:0] w;
        w = '0;
        w[MR_BL_LSB +: 3] = 3'(bl_code);
        w[MR_BT_BIT]      = burst_type[0];
        w[MR_CL_LSB +: 3] = 3'(cas_lat);
        w[MR_OP_LSB +: 2] = 2'b00;
        w[MR_WB_BIT]      = wb_single[0];
        return w;
    endfunction

    // Bits needed to hold the value v
    function automatic int bits_for(int v);
        int w;
        w = 1;
        while ((longint'(1) << w) <= longint'(v)) w++;
        return w;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sdinit_gap_timer.sv
module sdinit_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
    import sdinit_pkg::*;
#(
    parameter int STABLE_CYCLES = 20_000_000,
    parameter int REFRESH_COUNT = 4,
    parameter int T_RP          = 2,
    parameter int T_RC          = 7,
    parameter int T_MRD         = 2,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output sd_cmd_e          issue,
    output logic             cke_req,
    output logic             done
);
    localparam int REF_W = bits_for(REFRESH_COUNT);

    // The stabilisation load carries one extra count: the clock enable
    // flop sits one stage behind the state register.
    localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(STABLE_CYCLES);
    localparam logic [CNT_W-1:0] LD_RP     = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RC     = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD - 1);
    localparam logic [REF_W-1:0] REF_LAST  = REF_W'(REFRESH_COUNT - 1);

    typedef enum logic [2:0] {
        ST_POWER,
        ST_STABLE,
        ST_PRE_GAP,
        ST_REF_GAP,
        ST_LMR_GAP,
        ST_READY
    } seq_state_e;

    seq_state_e       state_q, state_n;
    logic [REF_W-1:0] ref_left_q, ref_left_n;

    always_comb begin
        state_n    = state_q;
        ref_left_n = ref_left_q;
        issue      = CMD_NOP;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (state_q)
            ST_POWER: begin
                tmr_load = 1'b1;
                tmr_val  = LD_STABLE;
                state_n  = ST_STABLE;
            end
            ST_STABLE: begin
                if (tmr_expired) begin
                    issue    = CMD_PRE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RP;
                    state_n  = ST_PRE_GAP;
                end
            end
            ST_PRE_GAP: begin
                if (tmr_expired) begin
                    issue      = CMD_REF;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_RC;
                    ref_left_n = REF_LAST;
                    state_n    = ST_REF_GAP;
                end
            end
            ST_REF_GAP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (ref_left_q == '0) begin
                        issue   = CMD_LMR;
                        tmr_val = LD_MRD;
                        state_n = ST_LMR_GAP;
                    end else begin
                        issue      = CMD_REF;
                        tmr_val    = LD_RC;
                        ref_left_n = ref_left_q - REF_W'(1);
                    end
                end
            end
            ST_LMR_GAP: begin
                if (tmr_expired) state_n = ST_READY;
            end
            default: begin
                state_n = ST_READY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_POWER;
            ref_left_q <= '0;
            done       <= 1'b0;
        end else begin
            state_q    <= state_n;
            ref_left_q <= ref_left_n;
            done       <= (state_n == ST_READY);
        end
    end

    assign cke_req = (state_q != ST_POWER);
endmodule

// File: rtl/sdinit_pin_drive.sv
module sdinit_pin_drive
    import sdinit_pkg::*;
#(
    parameter int              ADDR_W    = 13,
    parameter int              BANK_W    = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke_req,
    input  sd_cmd_e           issue,
    output logic              cke,
    output sd_pins_t          pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);
    localparam int ALL_BANKS_BIT = 10;

    logic [ADDR_W-1:0] addr_d;

    // Per-bit address selection: mode word on load-mode, the all-banks
    // flag on precharge, zero otherwise.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr_bit
        if (i == ALL_BANKS_BIT) begin : g_flag
            assign addr_d[i] = (issue == CMD_LMR) ? MODE_WORD[i] : (issue == CMD_PRE);
        end else begin : g_plain
            assign addr_d[i] = (issue == CMD_LMR) ? MODE_WORD[i] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke  <= 1'b0;
            pins <= PINS_NOP;
            addr <= '0;
            ba   <= '0;
        end else begin
            cke  <= cke_req;
            pins <= encode_cmd(issue);
            addr <= addr_d;
            ba   <= '0;
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdinit_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int BANK_W        = 2,
    parameter int STABLE_CYCLES = 20_000_000,
    parameter int REFRESH_COUNT = 4,
    parameter int T_RP          = 2,
    parameter int T_RC          = 7,
    parameter int T_MRD         = 2,
    parameter int BL_CODE       = 1,
    parameter int BURST_TYPE    = 0,
    parameter int CAS_LAT       = 3,
    parameter int WB_SINGLE     = 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              init_done
);
    localparam int CNT_W = bits_for(max4(STABLE_CYCLES, T_RP, T_RC, T_MRD));
    localparam logic [15:0]       MODE_FULL = mode_word(BL_CODE, BURST_TYPE, CAS_LAT, WB_SINGLE);
    localparam logic [ADDR_W-1:0] MODE_WORD = MODE_FULL[ADDR_W-1:0];

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    sd_cmd_e          issue;
    logic             cke_req;
    sd_pins_t         pins;

    sdinit_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdinit_ctrl #(
        .STABLE_CYCLES (STABLE_CYCLES),
        .REFRESH_COUNT (REFRESH_COUNT),
        .T_RP          (T_RP),
        .T_RC          (T_RC),
        .T_MRD         (T_MRD),
        .CNT_W         (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .issue       (issue),
        .cke_req     (cke_req),
        .done        (init_done)
    );

    sdinit_pin_drive #(
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W),
        .MODE_WORD (MODE_WORD)
    ) u_pins (
        .clk     (clk),
        .rst     (rst),
        .cke_req (cke_req),
        .issue   (issue),
        .cke     (sd_cke),
        .pins    (pins),
        .addr    (sd_addr),
        .ba      (sd_ba)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
endmodule

// File: rtl/sdinit_checker.sv
module sdinit_checker #(
    parameter int                ADDR_W    = 13,
    parameter int                BANK_W    = 2,
    parameter int                T_RP      = 2,
    parameter int                T_RC      = 7,
    parameter int                T_MRD     = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [BANK_W-1:0] sd_ba,
    input logic              init_done
);
    localparam logic [1:0] K_NONE = 2'd0;
    localparam logic [1:0] K_PRE  = 2'd1;
    localparam logic [1:0] K_REF  = 2'd2;
    localparam logic [1:0] K_LMR  = 2'd3;

    logic [3:0] p;
    logic is_nop, is_pre, is_ref, is_lmr;
    logic [1:0]  last_q;
    logic [31:0] since_q;

    assign p      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_nop = (p == 4'b0111);
    assign is_pre = (p == 4'b0010);
    assign is_ref = (p == 4'b0001);
    assign is_lmr = (p == 4'b0000);

    // Tracks the last command seen and the clocks since it
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= K_NONE;
            since_q <= '0;
        end else if (!is_nop) begin
            since_q <= 32'd1;
            last_q  <= is_pre ? K_PRE : (is_ref ? K_REF : K_LMR);
        end else if (since_q != 32'hFFFF_FFFF) begin
            since_q <= since_q + 32'd1;
        end
    end

    assert_cke_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        sd_cke |=> sd_cke);

    assert_idle_before_cke_R2: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> is_nop);

    assert_pre_flag_R3: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> (sd_addr == ADDR_W'(1 << 10)) && (sd_ba == '0));

    assert_gap_after_pre_R4: assert property (@(posedge clk) disable iff (rst)
        (!is_nop && last_q == K_PRE) |-> (since_q >= 32'(T_RP - 1)));

    assert_gap_after_ref_R5: assert property (@(posedge clk) disable iff (rst)
        (!is_nop && last_q == K_REF) |-> (since_q >= 32'(T_RC - 1)));

    assert_mode_word_R6: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (sd_addr == MODE_WORD) && (sd_ba == '0));

    assert_done_after_lmr_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (last_q == K_LMR) && (since_q >= 32'(T_MRD - 1)));

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_quiet_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        init_done |-> is_nop);

    assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_pre || is_ref || is_lmr);
endmodule

bind sdram_init_seq sdinit_checker #(
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W),
    .T_RP      (T_RP),
    .T_RC      (T_RC),
    .T_MRD     (T_MRD),
    .MODE_WORD (MODE_WORD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_ba     (sd_ba),
    .init_done (init_done)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/100ps
module tb_sdram_init_seq;
    localparam int S    = 40;
    localparam int N    = 4;
    localparam int TRP  = 2;
    localparam int TRC  = 7;
    localparam int TMRD = 2;
    localparam logic [12:0] EXP_MODE = 13'h231;

    localparam int EV_CKE = 0;
    localparam int EV_PRE = 1;
    localparam int EV_REF = 2;
    localparam int EV_LMR = 3;
    localparam int EV_RDY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_seen = 0;
    int bad_idle = 0;
    bit done_flag = 0;

    typedef struct {
        int          cyc;
        int          kind;
        logic [12:0] addr;
    } ev_t;
    ev_t expq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_init_seq #(
        .STABLE_CYCLES (S),
        .REFRESH_COUNT (N),
        .T_RP          (TRP),
        .T_RC          (TRC),
        .T_MRD         (TMRD)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .sd_cke    (sd_cke),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_addr   (sd_addr),
        .sd_ba     (sd_ba),
        .init_done (init_done)
    );

    function automatic string tag_of(int k);
        case (k)
            EV_CKE:  return "R2";
            EV_PRE:  return "R3";
            EV_REF:  return "R5";
            EV_LMR:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic push(int c, int k, logic [12:0] a);
        ev_t e;
        e.cyc = c; e.kind = k; e.addr = a;
        expq.push_back(e);
    endtask

    // Driver: predicts every event of one run from the release cycle.
    // refs_only > 0 stops the prediction after that many refreshes.
    task automatic push_run(int rel, int refs_only);
        int t;
        t = rel + 2;
        push(t, EV_CKE, '0);                 // R2
        t += S;
        push(t, EV_PRE, 13'h0400);           // R3: A10 high
        t += TRP;                            // R4: first refresh after tRP
        for (int i = 0; i < N; i++) begin
            push(t, EV_REF, '0);
            if (i == refs_only - 1) return;
            t += TRC;                        // R5
        end
        push(t, EV_LMR, EXP_MODE);           // R6
        push(t + TMRD, EV_RDY, '0);          // R7
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(string what);
        check(sd_cke == 1'b0 && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 &&
              sd_addr == '0 && sd_ba == '0 && init_done == 1'b0, "R1", what,
              {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done}, 6'b001110);
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: pops one expected item per observed event
    task automatic observe(int k, logic [12:0] a);
        ev_t e;
        if (expq.size() == 0) begin
            check(0, tag_of(k), "unexpected event kind", k, -1);
        end else begin
            e = expq.pop_front();
            check(e.kind == k, tag_of(e.kind), "event kind", k, e.kind);
            check(e.cyc == cyc, tag_of(e.kind), "event cycle", cyc, e.cyc);
            if (k != EV_CKE && k != EV_RDY)
                check(a == e.addr && sd_ba == '0, tag_of(e.kind), "address", int'(a), int'(e.addr));
        end
    endtask

    initial begin : monitor
        logic prev_cke, prev_rdy;
        logic [3:0] p;
        prev_cke = 0;
        prev_rdy = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_cke = 0;
                prev_rdy = 0;
            end else begin
                p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
                if (sd_cs_n !== 1'b0) bad_idle++;
                if (prev_cke && !sd_cke) bad_idle++;
                if (prev_rdy && !init_done) bad_idle++;
                if (sd_cke && !prev_cke) observe(EV_CKE, '0);
                case (p)
                    4'b0111: ;
                    4'b0010: observe(EV_PRE, sd_addr);
                    4'b0001: begin ref_seen++; observe(EV_REF, sd_addr); end
                    4'b0000: observe(EV_LMR, sd_addr);
                    default: bad_idle++;
                endcase
                if (init_done && !prev_rdy) observe(EV_RDY, '0);
                prev_cke = sd_cke;
                prev_rdy = init_done;
            end
        end
    end

    initial begin : watchdog
        repeat (100_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: sequence did not complete");
        finish_up();
    end

    initial begin : driver
        int rel;
        // Reset state
        repeat (4) @(negedge clk);
        check_reset_state("reset state at power-on");

        // Run 1: complete sequence
        rel = cyc;
        ref_seen = 0;
        push_run(rel, 0);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("first clock after release");
        wait (expq.size() == 0);
        check(ref_seen == N, "R4", "refresh count run 1", ref_seen, N);
        repeat (50) @(negedge clk);
        check(init_done == 1'b1, "R7", "done held after run 1", init_done, 1);

        // Reset after completion clears done
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state("reset after completion");

        // Run 2: reset in the cycle the second refresh is being issued
        rel = cyc;
        push_run(rel, 1);
        rst = 1'b0;
        wait (expq.size() == 0);
        while (cyc != rel + 2 + S + TRP + TRC - 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state("reset beats refresh issue");
        repeat (2) @(negedge clk);
        check(expq.size() == 0, "R1", "no event after colliding reset", expq.size(), 0);

        // Run 3: complete sequence after the interrupted one
        rel = cyc;
        ref_seen = 0;
        push_run(rel, 0);
        rst = 1'b0;
        wait (expq.size() == 0);
        check(ref_seen == N, "R4", "refresh count run 3", ref_seen, N);
        repeat (50) @(negedge clk);
        check(init_done == 1'b1, "R7", "done held after run 3", init_done, 1);
        check(bad_idle == 0, "R8", "illegal or non-idle cycles", bad_idle, 0);
        finish_up();
    end
endmodule